// File: doc/BRIEF.md
# HDLC NRZI Bit Sequencer with Zero-Bit Insertion

This block sits in front of a Bell 202 AFSK tone generator and tells it, one baud slot at a time, whether to swap between the mark and space tones. It is advanced by a sample strobe, which is the modulator's sample tick. The baud period does not have to be a whole number of samples: an 8.8 fixed-point residual decides on which sample each new bit slot begins. At the start of every slot the block picks the next line bit, encodes it as NRZI and, when the bit is a zero, sends a one-cycle toggle pulse.

A frame holds four parts in this order: a run of all-zero preamble octets, a run of opening flag octets (0x7E), `frame_len` payload bytes fetched through a byte-read port, and a run of closing flag octets. Flags go out most significant bit first. Payload bytes go out least significant bit first. Zero-bit insertion applies only inside the payload. When the frame is complete, `busy` falls and `done` pulses. Frame assembly and the checksum are the job of whoever fills the payload buffer.

Top module: `hdlc_nrzi_seq`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `busy`, `done` and `tone_toggle` are all low.
- R2: A `start` pulse restarts the frame from bit 0 with a zeroed residual and a zeroed ones count. It also discards any pending inserted zero, even when a frame is already running. The first iteration runs on the `start` cycle itself, so `busy` is high and `tone_toggle` reports the first preamble zero in the cycle after `start`.
- R3: Bit positions 0 to 8·N1−1 are zeros. The N2 opening and N3 closing octets are 0x7E, sent starting from bit 7. Payload byte k is requested on `rd_addr` = k = position/8 − (N1+N2) and sent starting from bit 0. `rd_data` must carry the addressed byte from the cycle after `rd_addr` changes.
- R4: NRZI: a line bit of 0 gives a one-cycle `tone_toggle` pulse in the cycle after the sample that begins its slot. A line bit of 1 gives no pulse.
- R5: Inside the payload, after five 1 bits in a row, the next slot carries an inserted toggle and does not advance the bit position, so no payload bit is lost. A payload 0 bit clears the ones count. An insertion that falls after the last payload bit goes out before the first closing flag.
- R6: Preamble and flag bits never update the ones count and never cause an insertion, even though a flag holds six 1 bits in a row.
- R7: The residual starts at 0 and grows by 256 on every iteration. Whenever it reaches SPB = (SAMPLE_RATE·256)/BAUD, SPB is subtracted and the bit position advances. A slot begins on an iteration whose residual, before the increment, is below 256.
- R8: When a slot begins with the position at (N1+N2+len+N3)·8, no toggle is sent. In the next cycle `busy` is low and `done` is high, and `done` stays high for exactly one cycle.
- R9: While `busy` is low and `start` is low, `sample_stb` has no effect: no toggle and no `done`.
- R10: When `start` and `sample_stb` are high in the same cycle, exactly one iteration runs.
- R11: `tone_toggle` and `done` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_stb | input | 1 | One-cycle modulator sample tick, at least 3 cycles apart |
| start | input | 1 | Begin (or restart) a frame |
| frame_len | input | LEN_W | Payload byte count, captured at `start` |
| rd_addr | output | LEN_W | Payload byte index being requested |
| rd_data | input | 8 | Payload byte at `rd_addr`, valid one cycle later |
| tone_toggle | output | 1 | One-cycle request to swap tones |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse when the frame has finished |

## Verification
Two events can collide in one cycle. A `start` can coincide with a sample strobe, and a restart can land in the middle of a payload while an inserted zero is pending. The bench raises `start` together with `sample_stb` and then checks that the whole toggle stream matches a single-iteration start. It also aborts a frame of all-ones bytes partway through the payload and restarts it. The toggle pattern after the restart must match a fresh frame slot for slot, with no leftover insertion and no extra iteration.

// File: rtl/hdlc_seq_pkg.sv
// Shared definitions for the HDLC NRZI bit sequencer.
// Assumes byte-wide payload and 8-bit flag octets.
package hdlc_seq_pkg;

    // Frame part that the current bit position falls in.
    typedef enum logic [2:0] {
        SEC_PRE   = 3'd0,
        SEC_OPEN  = 3'd1,
        SEC_DATA  = 3'd2,
        SEC_CLOSE = 3'd3,
        SEC_END   = 3'd4
    } sec_e;

    localparam logic [7:0] HDLC_FLAG = 8'h7E;
    localparam int         ONES_RUN  = 5;

endpackage

// File: rtl/hdlc_baud_accum.sv
// Fractional baud timer.
// Keeps the 8.8 residual of samples within the current baud slot. Flags the
// iteration that begins a slot and the one that moves the bit position on.
// Assumes SPB >= 256, i.e. at least one sample per baud.
module hdlc_baud_accum #(
    parameter int SPB   = 853,
    parameter int ACC_W = $clog2(SPB + 256) + 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic clear,
    output logic slot_start,
    output logic advance
);
    localparam logic [ACC_W-1:0] ONE_SAMPLE = ACC_W'(256);
    localparam logic [ACC_W-1:0] PERIOD     = ACC_W'(SPB);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_base;
    logic [ACC_W-1:0] acc_sum;

    // Residual as seen by this iteration (restart forces zero).
    assign acc_base   = clear ? '0 : acc_q;
    assign slot_start = acc_base < ONE_SAMPLE;
    assign acc_sum    = acc_base + ONE_SAMPLE;
    assign advance    = acc_sum >= PERIOD;

    // Register the residual after each iteration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (step) begin
            acc_q <= advance ? acc_sum - PERIOD : acc_sum;
        end
    end
endmodule

// File: rtl/hdlc_frame_src.sv
// Frame bit source.
// Maps a bit position to its frame part and raw line bit, and forms the
// payload byte address. Purely combinational. The payload byte is expected
// on rd_data one cycle after rd_addr settles.
module hdlc_frame_src
    import hdlc_seq_pkg::*;
#(
    parameter int N1    = 2,
    parameter int N2    = 2,
    parameter int N3    = 2,
    parameter int LEN_W = 8,
    parameter int POS_W = 13
) (
    input  logic [POS_W-1:0] pos,
    input  logic [LEN_W-1:0] len,
    input  logic [7:0]       rd_data,
    output logic [LEN_W-1:0] rd_addr,
    output sec_e             section,
    output logic             raw_bit
);
    localparam int BI_W = POS_W - 3;
    localparam logic [BI_W-1:0] OPEN_AT = BI_W'(N1);
    localparam logic [BI_W-1:0] DATA_AT = BI_W'(N1 + N2);

    logic [BI_W-1:0] byte_idx;
    logic [BI_W-1:0] close_at;
    logic [BI_W-1:0] end_at;
    logic [2:0]      bit_idx;
    logic [7:0]      flag_msb_first;

    assign byte_idx = pos[POS_W-1:3];
    assign bit_idx  = pos[2:0];
    assign close_at = DATA_AT + BI_W'(len);
    assign end_at   = close_at + BI_W'(N3);

    // Reverse the flag so the same bit index walks it from bit 7 down.
    for (genvar g = 0; g < 8; g++) begin : g_flag_rev
        assign flag_msb_first[g] = HDLC_FLAG[7-g];
    end

    // Decide the frame part from the byte index.
    always_comb begin
        if (byte_idx < OPEN_AT)       section = SEC_PRE;
        else if (byte_idx < DATA_AT)  section = SEC_OPEN;
        else if (byte_idx < close_at) section = SEC_DATA;
        else if (byte_idx < end_at)   section = SEC_CLOSE;
        else                          section = SEC_END;
    end

    // Pick the raw bit for this position.
    always_comb begin
        unique case (section)
            SEC_OPEN, SEC_CLOSE: raw_bit = flag_msb_first[bit_idx];
            SEC_DATA:            raw_bit = rd_data[bit_idx];
            default:             raw_bit = 1'b0;
        endcase
    end

    // Payload address, parked at zero outside the payload.
    always_comb begin
        if (section == SEC_DATA) rd_addr = LEN_W'(byte_idx - DATA_AT);
        else                     rd_addr = '0;
    end
endmodule

// File: rtl/hdlc_stuff_ctl.sv
// Zero-bit insertion control.
// Counts consecutive payload ones and arms an inserted zero after RUN of
// them. The caller feeds it payload bits only and consumes the pending
// insertion in the next slot.
module hdlc_stuff_ctl #(
    parameter int RUN   = 5,
    parameter int CNT_W = $clog2(RUN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic use_bit,
    input  logic bit_in,
    input  logic consume,
    output logic pending
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN - 1);

    logic [CNT_W-1:0] ones_q;
    logic [CNT_W-1:0] ones_base;
    logic             pend_q;

    assign ones_base = clear ? '0 : ones_q;
    assign pending   = clear ? 1'b0 : pend_q;

    // Track the ones run and the armed insertion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ones_q <= '0;
            pend_q <= 1'b0;
        end else begin
            if (consume || clear) begin
                pend_q <= 1'b0;
            end
            if (use_bit) begin
                if (!bit_in) begin
                    ones_q <= '0;
                end else if (ones_base == LAST) begin
                    ones_q <= '0;
                    pend_q <= 1'b1;
                end else begin
                    ones_q <= ones_base + CNT_W'(1);
                end
            end else if (clear) begin
                ones_q <= '0;
            end
        end
    end
endmodule

// File: rtl/hdlc_nrzi_seq.sv
// HDLC NRZI bit sequencer (top).
// Walks a preamble/flag/payload/flag frame at the baud rate set by the
// fractional timer, inserts zeros in the payload, and emits a tone-toggle
// pulse for every line zero. Assumes sample_stb pulses are at least three
// cycles apart and N1+N2+N3 > 0.
module hdlc_nrzi_seq
    import hdlc_seq_pkg::*;
#(
    parameter int N1          = 2,
    parameter int N2          = 2,
    parameter int N3          = 2,
    parameter int LEN_W       = 8,
    parameter int SAMPLE_RATE = 4000,
    parameter int BAUD        = 1200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_stb,
    input  logic             start,
    input  logic [LEN_W-1:0] frame_len,
    output logic [LEN_W-1:0] rd_addr,
    input  logic [7:0]       rd_data,
    output logic             tone_toggle,
    output logic             busy,
    output logic             done
);
    localparam int SPB   = (SAMPLE_RATE * 256) / BAUD;
    localparam int POS_W = $clog2((N1 + N2 + N3 + (1 << LEN_W)) * 8) + 1;

    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] pos_base;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] len_base;
    logic             busy_q;
    logic             done_q;
    logic             tog_q;

    logic iter;
    logic slot_start;
    logic adv;
    logic eval;
    logic fin;
    logic pend;
    logic hold;
    logic want_toggle;
    sec_e section;
    logic raw_bit;

    // One iteration per accepted sample, or immediately at start.
    assign iter     = start | (busy_q & sample_stb);
    assign pos_base = start ? '0 : pos_q;
    assign len_base = start ? frame_len : len_q;

    hdlc_baud_accum #(
        .SPB (SPB)
    ) u_accum (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (iter),
        .clear      (start),
        .slot_start (slot_start),
        .advance    (adv)
    );

    hdlc_frame_src #(
        .N1    (N1),
        .N2    (N2),
        .N3    (N3),
        .LEN_W (LEN_W),
        .POS_W (POS_W)
    ) u_src (
        .pos     (pos_base),
        .len     (len_base),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .section (section),
        .raw_bit (raw_bit)
    );

    assign eval        = iter & slot_start;
    assign fin         = eval & (section == SEC_END);
    assign hold        = eval & ~fin & pend;
    assign want_toggle = eval & ~fin & (pend | ~raw_bit);

    hdlc_stuff_ctl #(
        .RUN (ONES_RUN)
    ) u_stuff (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start),
        .use_bit (eval & ~fin & ~pend & (section == SEC_DATA)),
        .bit_in  (raw_bit),
        .consume (hold),
        .pending (pend)
    );

    // Bit position: advance on baud rollover, hold across an inserted zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (iter) begin
            pos_q <= pos_base + POS_W'(adv) - POS_W'(hold);
        end
    end

    // Capture the payload length for the whole frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
        end else if (start) begin
            len_q <= frame_len;
        end
    end

    // Frame activity and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= fin;
            if (start)    busy_q <= 1'b1;
            else if (fin) busy_q <= 1'b0;
        end
    end

    // Registered NRZI toggle request.
    always_ff @(posedge clk) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= want_toggle;
    end

    assign busy        = busy_q;
    assign done        = done_q;
    assign tone_toggle = tog_q;
endmodule

// File: rtl/hdlc_nrzi_seq_chk.sv
// Property checker for hdlc_nrzi_seq, attached by bind below.
// Observes only the top-level ports.
module hdlc_nrzi_seq_chk #(
    parameter int LEN_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             sample_stb,
    input logic [LEN_W-1:0] rd_addr,
    input logic             tone_toggle,
    input logic             busy,
    input logic             done
);
    assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    assert_addr_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !$past(start) && !$past(sample_stb)) |-> $stable(rd_addr));

    assert_toggle_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tone_toggle |-> busy);

    assert_done_clears_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> (!tone_toggle && !done));

    assert_no_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(tone_toggle && done));
endmodule

bind hdlc_nrzi_seq hdlc_nrzi_seq_chk #(
    .LEN_W (LEN_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .sample_stb  (sample_stb),
    .rd_addr     (rd_addr),
    .tone_toggle (tone_toggle),
    .busy        (busy),
    .done        (done)
);

// File: tb/hdlc_nrzi_seq_bench.sv
// Directed bench for hdlc_nrzi_seq: one task per scenario.
module hdlc_nrzi_seq_bench;
    localparam int N1   = 2;
    localparam int N2   = 2;
    localparam int N3   = 2;
    localparam int SR   = 4000;
    localparam int BAUD = 1200;
    localparam int SPB  = (SR * 256) / BAUD;
    localparam logic [7:0] FLAG = 8'h7E;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_stb = 1'b0;
    logic       start = 1'b0;
    logic [7:0] frame_len = '0;
    logic [7:0] rd_addr;
    logic [7:0] rd_data;
    logic       tone_toggle;
    logic       busy;
    logic       done;

    logic [7:0] mem [0:255];
    bit         sym [0:4095];
    int         nsym;
    int         total_cnt = 0;
    int         fail_cnt = 0;

    always #2.5 clk = ~clk;

    // Registered-read payload buffer.
    always @(posedge clk) rd_data <= mem[rd_addr];

    hdlc_nrzi_seq #(
        .N1 (N1), .N2 (N2), .N3 (N3), .LEN_W (8),
        .SAMPLE_RATE (SR), .BAUD (BAUD)
    ) u_hdlc_nrzi_seq (
        .clk (clk), .rst_n (rst_n), .sample_stb (sample_stb), .start (start),
        .frame_len (frame_len), .rd_addr (rd_addr), .rd_data (rd_data),
        .tone_toggle (tone_toggle), .busy (busy), .done (done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total_cnt++;
        if (!ok) begin
            fail_cnt++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(input bit t);
        sym[nsym] = t;
        nsym++;
    endtask

    // Expected per-slot toggle requests, built from the frame rules.
    task automatic build_syms(input int len);
        int ones;
        nsym = 0;
        ones = 0;
        for (int i = 0; i < N1 * 8; i++) push(1'b1);
        for (int o = 0; o < N2; o++)
            for (int b = 7; b >= 0; b--) push(!FLAG[b]);
        for (int i = 0; i < len; i++)
            for (int b = 0; b < 8; b++) begin
                push(!mem[i][b]);
                if (mem[i][b]) begin
                    ones++;
                    if (ones == 5) begin push(1'b1); ones = 0; end
                end else ones = 0;
            end
        for (int o = 0; o < N3; o++)
            for (int b = 7; b >= 0; b--) push(!FLAG[b]);
    endtask

    // Drive one iteration (start or strobe) and leave the bench at the
    // negedge where its registered outputs are visible.
    task automatic one_iter(input bit first, input bit with_stb);
        if (first) begin
            @(negedge clk);
            start = 1'b1;
            sample_stb = with_stb;
        end else begin
            repeat (2) @(negedge clk);
            sample_stb = 1'b1;
        end
        @(negedge clk);
        start = 1'b0;
        sample_stb = 1'b0;
    endtask

    // Run a frame and compare every sample's toggle/done to the model.
    task automatic run_frame(input int len, input bit with_stb, input string tag);
        int  acc, j, bad, exp_k, got_k, bad_k, bad_act, bad_exp;
        bit  e_tog, e_done;
        build_syms(len);
        frame_len = 8'(len);
        acc = 0; j = 0; bad = 0; exp_k = -1; got_k = -1; bad_k = -1;
        bad_act = 0; bad_exp = 0;
        for (int k = 0; k < 6000; k++) begin
            one_iter(k == 0, with_stb);
            e_tog = 1'b0; e_done = 1'b0;
            if (acc < 256) begin
                if (j < nsym) e_tog = sym[j];
                else if (j == nsym) e_done = 1'b1;
                j++;
            end
            acc += 256;
            if (acc >= SPB) acc -= SPB;
            if (k == 0) begin
                chk(busy === 1'b1, "R2", {tag, " busy after start"}, busy, 1);
                chk(tone_toggle === 1'b1, "R2", {tag, " first preamble toggle"}, tone_toggle, 1);
            end
            if (tone_toggle !== e_tog || done !== e_done) begin
                if (bad == 0) begin
                    bad_k = k;
                    bad_act = {tone_toggle, done};
                    bad_exp = {e_tog, e_done};
                end
                bad++;
            end
            if (done === 1'b1 && got_k < 0) got_k = k;
            if (e_done) begin exp_k = k; break; end
        end
        chk(bad == 0, "R4", $sformatf("%s toggle stream (R3/R5/R6/R7), first bad sample %0d, {tog,done}",
            tag, bad_k), bad_act, bad_exp);
        chk(got_k == exp_k, "R8", {tag, " done sample"}, got_k, exp_k);
        chk(busy === 1'b0, "R8", {tag, " busy low at end"}, busy, 0);
    endtask

    task automatic run_partial(input int len, input int n);
        frame_len = 8'(len);
        for (int k = 0; k < n; k++) one_iter(k == 0, 1'b0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0 && tone_toggle === 1'b0, "R1",
            "outputs in reset", {busy, done, tone_toggle}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0 && tone_toggle === 1'b0, "R1",
            "outputs after release", {busy, done, tone_toggle}, 0);
    endtask

    task automatic t_mixed;
        mem[0] = 8'hA5; mem[1] = 8'h3C; mem[2] = 8'h01; mem[3] = 8'h80;
        run_frame(4, 1'b0, "mixed");
    endtask

    task automatic t_stuff;
        mem[0] = 8'hFF; mem[1] = 8'hFF; mem[2] = 8'h1F; mem[3] = 8'hF8;
        run_frame(4, 1'b0, "R5 stuffing");
    endtask

    task automatic t_empty;
        run_frame(0, 1'b0, "R8 empty payload");
    endtask

    task automatic t_restart;
        mem[0] = 8'hFF; mem[1] = 8'hFF; mem[2] = 8'hFF;
        // Abort well into the payload of ones, then restart.
        run_partial(3, 130);
        run_frame(3, 1'b0, "R2 restart");
    endtask

    task automatic t_start_strobe;
        mem[0] = 8'h5A; mem[1] = 8'hE7;
        run_frame(2, 1'b1, "R10 start+strobe");
    endtask

    task automatic t_idle;
        int seen;
        seen = 0;
        for (int k = 0; k < 8; k++) begin
            one_iter(1'b0, 1'b0);
            if (tone_toggle !== 1'b0 || done !== 1'b0 || busy !== 1'b0) seen++;
        end
        chk(seen == 0, "R9", "idle strobes ignored", seen, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        t_reset();
        t_mixed();
        t_idle();
        t_stuff();
        t_empty();
        t_restart();
        t_start_strobe();
        $display("%0d/%0d checks passed", total_cnt - fail_cnt, total_cnt);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fail_cnt++;
        total_cnt++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total_cnt - fail_cnt, total_cnt);
        $finish;
    end
endmodule